// File: doc/BRIEF.md
# Fuse-Configured Product-Term Array Core

This block is the configurable heart of a ten-cell programmable logic device. A nonvolatile-style fuse map, written and read one bit per clock through a small serial configuration port, decides which input literals take part in each product term. Twenty signals drive the array: ten dedicated inputs and ten feedback lines, one from each output cell. Each signal is offered in true and complement form, so every product-term row spans forty fuse columns. Each of the ten cells owns eight rows: four data terms, then one term each for asynchronous reset, asynchronous preset, clock and output enable. The term outputs and a per-cell polarity bit go straight to the macrocell logic that sits downstream.

Beyond the array and polarity fuses, the map holds a 64-bit user signature and one security fuse. Programming can only clear fuses, never set them. Once the security fuse is cleared, readback of the array and polarity region returns zeros, while the signature stays readable. Only an erase restores the erased value of every fuse, the security fuse included.

A small controller runs the configuration port. Its states are ST_IDLE (no access), ST_PROG (each accepted bit is written at the address counter), ST_READ (each request returns the fuse at the address counter) and ST_ERASE (sets every fuse back to 1 in one cycle). A start pulse moves the controller from any state into the state its opcode names and loads the address counter. Opcode idle leads to ST_IDLE, program to ST_PROG, read to ST_READ and erase to ST_ERASE. ST_ERASE returns to ST_IDLE by itself after one cycle. ST_PROG and ST_READ stay where they are until the next start pulse.

Top module: `pla_fuse_core`

## Requirements
- R1: After reset every fuse holds 1 and the security fuse is clear. The controller is in ST_IDLE with address 0, rd_valid is 0, and every pt_out and pol_out bit is 1.
- R2: Signal s is din[s] for s below 10 and fb[s-10] otherwise. Column 2s of a row is the true literal of signal s and column 2s+1 is its complement. A fuse of 0 includes its literal in the term and a fuse of 1 leaves it out. A row is 1 exactly when every included literal is 1, so a row of all 1s gives 1, and a row with both fuses of one signal at 0 gives 0.
- R3: Row r is pt_out[r], with r = 8*cell + k. Here k is 0 to 3 for the data terms, 4 for reset, 5 for preset, 6 for clock and 7 for output enable. The fuse at column c of row r sits at address 40*r + c, so cell n spans addresses 320n to 320n+319.
- R4: pol_out[n] equals the fuse at address 3200+n.
- R5: In ST_PROG, each cycle with cfg_bit_valid high and cfg_start low does two things. It replaces the fuse at the address counter with that fuse ANDed with cfg_bit_in, and it advances the counter, which holds at 4095. A write to an address of 3275 or more changes nothing.
- R6: In ST_READ, each cycle with cfg_bit_valid high and cfg_start low advances the counter. On the next cycle rd_valid is 1 and rd_bit carries the fuse at the address that was read. Addresses of 3275 or more read as 0, and rd_valid is 0 in every other cycle.
- R7: Signature bits occupy addresses 3210 to 3273, most significant bit first, and read back whatever the state of the security fuse.
- R8: The security fuse sits at address 3274 and is set when it holds 0. While it is set, reads of addresses 0 to 3209 return 0, and addresses 3210 to 3274 still read their true values. Programming cannot clear the security fuse, and the terms keep working.
- R9: cfg_op values are 0 idle, 1 program, 2 read and 3 erase. After an erase start, the controller spends one cycle in ST_ERASE, which sets every fuse to 1, and then moves to ST_IDLE. Bits offered during ST_ERASE are ignored.
- R10: On a cycle with cfg_start high, the controller takes the opcode's state and loads the counter from cfg_addr. A cfg_bit_valid in that same cycle neither writes nor reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Starts a configuration operation |
| cfg_op | input | 2 | Operation: 0 idle, 1 program, 2 read, 3 erase |
| cfg_addr | input | 12 | Start fuse address, loaded with cfg_start |
| cfg_bit_valid | input | 1 | One serial bit request this cycle |
| cfg_bit_in | input | 1 | Serial fuse bit for programming |
| rd_valid | output | 1 | Readback bit is valid |
| rd_bit | output | 1 | Readback fuse value |
| din | input | 10 | Dedicated array inputs |
| fb | input | 10 | Feedback lines from the ten cells |
| pt_out | output | 80 | Product terms, eight per cell |
| pol_out | output | 10 | Per-cell polarity fuse |

## Verification
A misaddressed fuse write shows up at pt_out in the cycle after the write edge. The row it lands in flips for input patterns that the correct row would not respond to. The reference model evaluates all eighty rows against the driven inputs on every clock, so the first pattern that exposes the error is flagged. A wrong address counter or a broken security decision shows up one cycle after the read request, as a wrong rd_bit. A failed erase leaves terms at 0 in the very next cycle.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_READ  = 2'd2,
        OP_ERASE = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_READ  = 2'd2,
        ST_ERASE = 2'd3
    } cfg_state_e;
endpackage

// File: rtl/pla_cfg_ctrl.sv
`timescale 1ns/1ps
module pla_cfg_ctrl
    import pla_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [1:0]    cfg_op,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_bit_valid,
    output logic          wr_en,
    output logic          rd_en,
    output logic          erase_en,
    output logic [AW-1:0] cur_addr
);
    cfg_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (cfg_start) begin
            unique case (cfg_op_e'(cfg_op))
                OP_IDLE:  state_d = ST_IDLE;
                OP_PROG:  state_d = ST_PROG;
                OP_READ:  state_d = ST_READ;
                OP_ERASE: state_d = ST_ERASE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE, ST_PROG, ST_READ: state_d = state_q;
                ST_ERASE:                  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        erase_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PROG:  wr_en    = cfg_bit_valid && !cfg_start;
            ST_READ:  rd_en    = cfg_bit_valid && !cfg_start;
            ST_ERASE: erase_en = 1'b1;
        endcase
    end

    // address counter, saturating at all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (cfg_start)
            cur_addr <= cfg_addr;
        else if ((wr_en || rd_en) && (cur_addr != '1))
            cur_addr <= cur_addr + 1'b1;
    end

    assert_erase_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && !cfg_start) |=> (state_q == ST_IDLE));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past((wr_en || rd_en) && !cfg_start && (cur_addr != '1))
            |-> (cur_addr == $past(cur_addr) + 1'b1));

    assert_start_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (cur_addr == $past(cfg_addr)));
endmodule

// File: rtl/pla_fuse_store.sv
`timescale 1ns/1ps
module pla_fuse_store #(
    parameter int AW        = 12,
    parameter int ARR_FUSES = 3200,
    parameter int N_CELL    = 10,
    parameter int SIG_BITS  = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 erase_en,
    input  logic [AW-1:0]        addr,
    input  logic                 wr_bit,
    output logic [ARR_FUSES-1:0] arr_fuses,
    output logic [N_CELL-1:0]    pol_fuses,
    output logic                 rd_valid,
    output logic                 rd_bit
);
    localparam int PROT_LIMIT = ARR_FUSES + N_CELL;
    localparam int SEC_ADDR   = PROT_LIMIT + SIG_BITS;
    localparam int N_FUSE     = SEC_ADDR + 1;

    logic [N_FUSE-1:0] fuse_q;
    logic              secure;
    logic              in_range;
    logic              readable;

    assign secure    = ~fuse_q[SEC_ADDR];
    assign in_range  = addr < AW'(N_FUSE);
    assign readable  = in_range && !(secure && (addr < AW'(PROT_LIMIT)));
    assign arr_fuses = fuse_q[ARR_FUSES-1:0];
    assign pol_fuses = fuse_q[ARR_FUSES +: N_CELL];

    // programming only clears; erase sets everything
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fuse_q <= '1;
        else if (erase_en)
            fuse_q <= '1;
        else if (wr_en && in_range)
            fuse_q[addr] <= fuse_q[addr] & wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_bit <= readable ? fuse_q[addr] : 1'b0;
        end
    end

    assert_only_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase_en) |-> ((fuse_q & ~$past(fuse_q)) == '0));

    assert_erase_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase_en) |-> (&fuse_q));

    assert_blocked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(secure && (addr < AW'(PROT_LIMIT)))) |-> !rd_bit);

    assert_secure_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(secure && !erase_en) |-> secure);
endmodule

// File: rtl/pla_term_array.sv
`timescale 1ns/1ps
module pla_term_array #(
    parameter int N_DIN  = 10,
    parameter int N_CELL = 10,
    parameter int N_ROWS = 80
) (
    input  logic [N_ROWS*2*(N_DIN+N_CELL)-1:0] arr_fuses,
    input  logic [N_DIN-1:0]                   din,
    input  logic [N_CELL-1:0]                  fb,
    output logic [N_ROWS-1:0]                  pt
);
    localparam int N_SIG = N_DIN + N_CELL;
    localparam int N_COL = 2 * N_SIG;

    logic [N_SIG-1:0] sig;
    logic [N_COL-1:0] lit;

    assign sig = {fb, din};

    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[2*s]   = sig[s];
        assign lit[2*s+1] = ~sig[s];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign pt[r] = &(arr_fuses[r*N_COL +: N_COL] | lit);

        // both literals of signal 0 included: term can never be true
        always_comb begin
            assert_contradict_R2: assert (arr_fuses[r*N_COL] || arr_fuses[r*N_COL+1] || !pt[r]);
        end
    end
endmodule

// File: rtl/pla_fuse_core.sv
`timescale 1ns/1ps
module pla_fuse_core #(
    parameter int N_DIN      = 10,
    parameter int N_CELL     = 10,
    parameter int DATA_TERMS = 4,
    parameter int SIG_BITS   = 64,
    localparam int ROWS_PER_CELL = DATA_TERMS + 4,
    localparam int N_ROWS    = N_CELL * ROWS_PER_CELL,
    localparam int N_COL     = 2 * (N_DIN + N_CELL),
    localparam int ARR_FUSES = N_ROWS * N_COL,
    localparam int N_FUSE    = ARR_FUSES + N_CELL + SIG_BITS + 1,
    localparam int AW        = $clog2(N_FUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_op,
    input  logic [AW-1:0]     cfg_addr,
    input  logic              cfg_bit_valid,
    input  logic              cfg_bit_in,
    output logic              rd_valid,
    output logic              rd_bit,
    input  logic [N_DIN-1:0]  din,
    input  logic [N_CELL-1:0] fb,
    output logic [N_ROWS-1:0] pt_out,
    output logic [N_CELL-1:0] pol_out
);
    logic                 wr_en;
    logic                 rd_en;
    logic                 erase_en;
    logic [AW-1:0]        cur_addr;
    logic [ARR_FUSES-1:0] arr_fuses;

    pla_cfg_ctrl #(.AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_start     (cfg_start),
        .cfg_op        (cfg_op),
        .cfg_addr      (cfg_addr),
        .cfg_bit_valid (cfg_bit_valid),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .erase_en      (erase_en),
        .cur_addr      (cur_addr)
    );

    pla_fuse_store #(
        .AW        (AW),
        .ARR_FUSES (ARR_FUSES),
        .N_CELL    (N_CELL),
        .SIG_BITS  (SIG_BITS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .erase_en  (erase_en),
        .addr      (cur_addr),
        .wr_bit    (cfg_bit_in),
        .arr_fuses (arr_fuses),
        .pol_fuses (pol_out),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit)
    );

    pla_term_array #(
        .N_DIN  (N_DIN),
        .N_CELL (N_CELL),
        .N_ROWS (N_ROWS)
    ) u_terms (
        .arr_fuses (arr_fuses),
        .din       (din),
        .fb        (fb),
        .pt        (pt_out)
    );
endmodule

// File: tb/test_pla_fuse_core.sv
`timescale 1ns/1ps
module test_pla_fuse_core;
    localparam int NFUSE = 3275;
    localparam int PROT  = 3210;
    localparam int NROW  = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [11:0] cfg_addr = '0;
    logic        cfg_bit_valid = 1'b0;
    logic        cfg_bit_in = 1'b1;
    logic        rd_valid;
    logic        rd_bit;
    logic [9:0]  din = '0;
    logic [9:0]  fb = '0;
    logic [79:0] pt_out;
    logic [9:0]  pol_out;

    int checks = 0;
    int errors = 0;

    bit ref_fuse [NFUSE];
    int ref_state = 0;
    int ref_addr = 0;
    bit ref_rv = 0;
    bit ref_rb = 0;

    always #2.5 clk = ~clk;

    pla_fuse_core i_pla_fuse_core (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_op(cfg_op),
        .cfg_addr(cfg_addr), .cfg_bit_valid(cfg_bit_valid), .cfg_bit_in(cfg_bit_in),
        .rd_valid(rd_valid), .rd_bit(rd_bit), .din(din), .fb(fb),
        .pt_out(pt_out), .pol_out(pol_out)
    );

    function automatic bit ref_read(int a);
        if (a >= NFUSE) return 1'b0;
        if (!ref_fuse[NFUSE-1] && a < PROT) return 1'b0;
        return ref_fuse[a];
    endfunction

    function automatic bit ref_pt(int r);
        for (int s = 0; s < 20; s++) begin
            bit v;
            v = (s < 10) ? din[s] : fb[s-10];
            if (!ref_fuse[r*40+2*s] && !v) return 1'b0;
            if (!ref_fuse[r*40+2*s+1] && v) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic model_update();
        bit nrv;
        nrv = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < NFUSE; i++) ref_fuse[i] = 1'b1;
            ref_state = 0; ref_addr = 0; ref_rv = 0; ref_rb = 0;
            return;
        end
        if (ref_state == 3) begin
            for (int i = 0; i < NFUSE; i++) ref_fuse[i] = 1'b1;
        end else if (!cfg_start && cfg_bit_valid && ref_state == 1) begin
            if (ref_addr < NFUSE) ref_fuse[ref_addr] = ref_fuse[ref_addr] & cfg_bit_in;
            if (ref_addr != 4095) ref_addr++;
        end else if (!cfg_start && cfg_bit_valid && ref_state == 2) begin
            nrv = 1'b1;
            ref_rb = ref_read(ref_addr);
            if (ref_addr != 4095) ref_addr++;
        end
        if (cfg_start) begin
            ref_state = int'(cfg_op);
            ref_addr = int'(cfg_addr);
        end else if (ref_state == 3) begin
            ref_state = 0;
        end
        ref_rv = nrv;
    endtask

    task automatic compare();
        for (int r = 0; r < NROW; r++) begin
            checks++;
            if (pt_out[r] !== ref_pt(r)) begin
                errors++;
                $display("FAIL R2 R3 pt_out[%0d] act %b exp %b", r, pt_out[r], ref_pt(r));
            end
        end
        for (int n = 0; n < 10; n++) begin
            checks++;
            if (pol_out[n] !== ref_fuse[3200+n]) begin
                errors++;
                $display("FAIL R4 pol_out[%0d] act %b exp %b", n, pol_out[n], ref_fuse[3200+n]);
            end
        end
        checks++;
        if (rd_valid !== ref_rv) begin
            errors++;
            $display("FAIL R6 rd_valid act %b exp %b", rd_valid, ref_rv);
        end else if (ref_rv) begin
            checks++;
            if (rd_bit !== ref_rb) begin
                errors++;
                $display("FAIL R6 rd_bit act %b exp %b", rd_bit, ref_rb);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %b exp %b", tag, act, exp);
        end
    endtask

    task automatic start(input int op, input int a);
        cfg_start = 1'b1; cfg_op = 2'(op); cfg_addr = 12'(a);
        tick();
        cfg_start = 1'b0;
    endtask

    task automatic prog(input int a, input bit b);
        start(1, a);
        cfg_bit_valid = 1'b1; cfg_bit_in = b;
        tick();
        cfg_bit_valid = 1'b0; cfg_bit_in = 1'b1;
    endtask

    task automatic read1(input int a, output logic v);
        start(2, a);
        cfg_bit_valid = 1'b1;
        tick();
        cfg_bit_valid = 1'b0;
        chk("R6 rd_valid after request", rd_valid, 1'b1);
        v = rd_bit;
    endtask

    task automatic erase_all();
        start(3, 0);
        cfg_bit_valid = 1'b1; cfg_bit_in = 1'b0;
        tick();
        cfg_bit_valid = 1'b0; cfg_bit_in = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 pt_out all ones", &pt_out, 1'b1);
        chk("R1 pol_out all ones", &pol_out, 1'b1);
        chk("R1 rd_valid low", rd_valid, 1'b0);

        // R2 R3: cell 3 data term 0 = din[2] & ~fb[5]
        prog(964, 1'b0);
        prog(991, 1'b0);
        din = 10'b0000000100; fb = 10'b0000000000; tick();
        chk("R2 term true", pt_out[24], 1'b1);
        chk("R3 neighbour row untouched", pt_out[25], 1'b1);
        din = 10'b0; tick();
        chk("R2 true literal false", pt_out[24], 1'b0);
        din = 10'b0000000100; fb = 10'b0000100000; tick();
        chk("R2 complement literal false", pt_out[24], 1'b0);

        // R3 cell 9 reset row uses din[0]
        prog(3040, 1'b0);
        din = 10'b0; tick();
        chk("R3 cell9 reset term", pt_out[76], 1'b0);
        din = 10'b1; tick();
        chk("R3 cell9 reset term on", pt_out[76], 1'b1);

        // R2 contradiction: both literals of din[1] in cell 0 row 1
        prog(42, 1'b0); prog(43, 1'b0);
        din = 10'b10; tick();
        chk("R2 contradiction row", pt_out[1], 1'b0);

        // R4 polarity
        prog(3207, 1'b0);
        chk("R4 pol_out[7]", pol_out[7], 1'b0);
        chk("R4 pol_out[6]", pol_out[6], 1'b1);

        // R5 stream write with AND semantics
        start(1, 1000);
        cfg_bit_valid = 1'b1;
        cfg_bit_in = 1'b0; tick();
        cfg_bit_in = 1'b1; tick();
        cfg_bit_in = 1'b0; tick();
        cfg_bit_valid = 1'b0;
        prog(1000, 1'b1);
        prog(3280, 1'b0);
        read1(1000, v); chk("R5 stays cleared", v, 1'b0);
        read1(1001, v); chk("R5 one keeps fuse", v, 1'b1);
        read1(1002, v); chk("R5 stream third bit", v, 1'b0);

        // R6 reads
        read1(964, v); chk("R6 read programmed", v, 1'b0);
        read1(965, v); chk("R6 read erased", v, 1'b1);
        read1(3300, v); chk("R6 out of range read", v, 1'b0);

        // R10 start with bit in same cycle
        start(1, 600);
        cfg_start = 1'b1; cfg_op = 2'd1; cfg_addr = 12'd500;
        cfg_bit_valid = 1'b1; cfg_bit_in = 1'b0;
        tick();
        cfg_start = 1'b0; cfg_bit_valid = 1'b0; cfg_bit_in = 1'b1;
        read1(600, v); chk("R10 old address not written", v, 1'b1);
        read1(500, v); chk("R10 new address not written", v, 1'b1);

        // R7 R8 security
        prog(3210, 1'b0);
        prog(3274, 1'b0);
        read1(965, v); chk("R8 array read blocked", v, 1'b0);
        read1(3208, v); chk("R8 polarity read blocked", v, 1'b0);
        read1(3210, v); chk("R7 signature msb readable", v, 1'b0);
        read1(3211, v); chk("R7 signature bit readable", v, 1'b1);
        read1(3274, v); chk("R8 security fuse readable", v, 1'b0);
        prog(3274, 1'b1);
        read1(965, v); chk("R8 security not cleared by program", v, 1'b0);
        din = 10'b0000000100; fb = 10'b0; tick();
        chk("R8 terms active while secure", pt_out[24], 1'b1);

        // R9 erase
        erase_all();
        tick();
        chk("R9 all terms after erase", &pt_out, 1'b1);
        chk("R9 polarity after erase", &pol_out, 1'b1);
        read1(965, v); chk("R9 security cleared", v, 1'b1);
        read1(0, v); chk("R9 address 0 erased and bit in ERASE ignored", v, 1'b1);

        // random phase compared every clock
        for (int i = 0; i < 400; i++) begin
            din = 10'($urandom); fb = 10'($urandom);
            if ((i % 6) == 0) begin
                int r;
                r = int'($urandom % 80);
                prog(r*40 + int'($urandom % 40), 1'b0);
            end else begin
                tick();
            end
        end

        // readback sweep
        start(2, 3180);
        cfg_bit_valid = 1'b1;
        for (int i = 0; i < 120; i++) tick();
        cfg_bit_valid = 1'b0;
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule